// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight status bits of a small processor core: the ALU condition flags (carry, zero, negative, overflow, sign, half carry), a single-bit transfer cell used to move one bit between a register operand and another register, and the master interrupt enable. The ALU presents its operands, its result and its carry out each cycle it executes. A per-flag mask chooses which condition flags that operation may change, so logic operations can leave carry and half carry untouched. Conditional branches read the flags straight away, without a separate compare.

Software can load the whole register in one cycle. When the interrupt controller accepts a request, the enable bit is cleared in hardware. A return-from-interrupt sets it again. Nothing else is saved or restored around interrupts. The sign bit is not stored independently: after every update it is recomputed as negative xor overflow. A bit-store picks one bit of a source operand into the transfer cell. A bit-load returns a destination operand with the selected bit replaced by the transfer cell.

Top module: `cpu_flag_reg`

## Requirements
- R1: After reset every bit of `sreg_q` is 0, `t_out` is 0 and `irq_permit` is 0.
- R2: When `alu_we` is high, the flags selected by the mask take new values at the next clock edge: half carry (bit 5) is the carry out of operand bit 3, overflow (bit 3) is set when both operands have the same sign and the result sign differs from it, negative (bit 2) is result bit 7, zero (bit 1) is set when the result is all zeros, and carry (bit 0) is `alu_cout`.
- R3: A flag whose bit in `alu_mask` is 0 keeps its value through an ALU update. Mask bits 7, 6 and 4 have no effect, so an update never changes I or T.
- R4: Bit 4 (S) always equals bit 2 xor bit 3 after any update, including a software write that supplies an inconsistent S.
- R5: `sw_we` loads `sw_data` into the register at the next edge, apart from S. It takes priority over return-from-interrupt, the ALU update and bit-store in the same cycle.
- R6: `irq_take` makes bit 7 (I) 0 at the next edge, even when `sw_we` or `reti` in the same cycle would set it.
- R7: `reti` without `irq_take` or `sw_we` sets I at the next edge. An ALU update or bit-store in the same cycle still takes effect.
- R8: `bst_en` without `sw_we` copies bit `bit_sel` of `bst_src` into bit 6 (T). `t_out` shows T.
- R9: `bld_res` is `bld_dst` with bit `bit_sel` replaced by the current T. This is combinational.
- R10: `irq_permit` is high only when `irq_pending` is high and I is 1. This is combinational.
- R11: `irq_take` and `reti` on their own change only bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_we | input | 1 | ALU flag update this cycle |
| alu_mask | input | 8 | Per-flag update mask, in register bit positions |
| op_a | input | DATA_W | ALU first operand |
| op_b | input | DATA_W | ALU second operand |
| alu_res | input | DATA_W | ALU result |
| alu_cout | input | 1 | ALU carry out |
| sw_we | input | 1 | Software write strobe |
| sw_data | input | 8 | Software write value |
| bst_en | input | 1 | Bit-store strobe |
| bst_src | input | DATA_W | Bit-store source operand |
| bit_sel | input | IDX_W | Bit index for bit-store and bit-load |
| bld_dst | input | DATA_W | Bit-load destination operand |
| irq_take | input | 1 | Interrupt accepted strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_pending | input | 1 | Request already gated by its individual enable |
| sreg_q | output | 8 | Register value (I,T,H,S,V,N,Z,C from bit 7 down) |
| t_out | output | 1 | Transfer bit T |
| bld_res | output | DATA_W | Bit-load result |
| irq_permit | output | 1 | Request passed by the master enable |

## Verification
The bench drives additions that sit right on the edges: a nibble carry alone, signed overflow both ways, a full wrap to zero, and two negative operands. A design that took half carry from the wrong bit, or overflow from the carry, would store the wrong flags there. Masked updates, including an all-ones mask, check that logic-type operations keep carry and that I and T never follow the ALU. Coincident strobes are applied together (software write with return, ALU and bit-store; interrupt accept with software write or return) to expose a wrong priority, a late I clear or an enable that comes back on. A software write with an inconsistent S catches a register that stores S instead of deriving it.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
  localparam int SR_W = 8;
  localparam int FB_I = 7;
  localparam int FB_T = 6;
  localparam int FB_H = 5;
  localparam int FB_S = 4;
  localparam int FB_V = 3;
  localparam int FB_N = 2;
  localparam int FB_Z = 1;
  localparam int FB_C = 0;
  // condition flags an ALU mask may touch (S is always derived)
  localparam logic [SR_W-1:0] ALU_FLAGS = 8'b0010_1111;

  // force sign bit to negative xor overflow
  function automatic logic [SR_W-1:0] sign_fix(input logic [SR_W-1:0] v);
    logic [SR_W-1:0] o;
    o       = v;
    o[FB_S] = v[FB_N] ^ v[FB_V];
    return o;
  endfunction
endpackage

// File: rtl/sreg_flag_merge.sv
module sreg_flag_merge
  import flagreg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [5:0]        cur,
  input  logic              alu_we,
  input  logic [SR_W-1:0]   alu_mask,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  output logic [5:0]        merged,
  output logic              alu_evt
);
  localparam int MSB = DATA_W - 1;

  function automatic logic nib_carry(input logic a3, input logic b3, input logic r3);
    return (a3 & b3) | (a3 & ~r3) | (b3 & ~r3);
  endfunction

  function automatic logic sgn_ovf(input logic as, input logic bs, input logic rs);
    return (as & bs & ~rs) | (~as & ~bs & rs);
  endfunction

  logic [5:0] raw;
  logic [5:0] eff;

  always_comb begin
    raw       = '0;
    raw[FB_H] = nib_carry(op_a[3], op_b[3], res[3]);
    raw[FB_V] = sgn_ovf(op_a[MSB], op_b[MSB], res[MSB]);
    raw[FB_N] = res[MSB];
    raw[FB_Z] = ~|res;
    raw[FB_C] = cout;
  end

  assign eff     = alu_mask[5:0] & ALU_FLAGS[5:0] & {6{alu_we}};
  assign merged  = (cur & ~eff) | (raw & eff);
  assign alu_evt = alu_we & |eff;
endmodule

// File: rtl/sreg_tbit.sv
module sreg_tbit #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              cur_t,
  input  logic              bst_en,
  input  logic [DATA_W-1:0] bst_src,
  input  logic [IDX_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] bld_dst,
  output logic              t_next,
  output logic [DATA_W-1:0] bld_res
);
  assign t_next = bst_en ? bst_src[bit_sel] : cur_t;

  for (genvar k = 0; k < DATA_W; k++) begin : g_ins
    assign bld_res[k] = (bit_sel == IDX_W'(k)) ? cur_t : bld_dst[k];
  end
endmodule

// File: rtl/sreg_ie_ctrl.sv
module sreg_ie_ctrl (
  input  logic cur_i,
  input  logic sw_we,
  input  logic sw_i,
  input  logic reti,
  input  logic irq_take,
  input  logic irq_pending,
  output logic i_next,
  output logic irq_permit,
  output logic ev_take,
  output logic ev_ret
);
  assign ev_take = irq_take;
  assign ev_ret  = reti & ~irq_take & ~sw_we;

  always_comb begin
    i_next = cur_i;
    if (reti)     i_next = 1'b1;
    if (sw_we)    i_next = sw_i;
    if (irq_take) i_next = 1'b0;
  end

  assign irq_permit = cur_i & irq_pending;
endmodule

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg
  import flagreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_we,
  input  logic [SR_W-1:0]   alu_mask,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  input  logic              sw_we,
  input  logic [SR_W-1:0]   sw_data,
  input  logic              bst_en,
  input  logic [DATA_W-1:0] bst_src,
  input  logic [IDX_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] bld_dst,
  input  logic              irq_take,
  input  logic              reti,
  input  logic              irq_pending,
  output logic [SR_W-1:0]   sreg_q,
  output logic              t_out,
  output logic [DATA_W-1:0] bld_res,
  output logic              irq_permit
);
  logic [SR_W-1:0] sr;
  logic [SR_W-1:0] body;
  logic [SR_W-1:0] sr_nxt;
  logic [5:0]      merged;
  logic            alu_evt;
  logic            t_next;
  logic            i_next;
  logic            ev_take;
  logic            ev_ret;
  logic            ev_bst;

  sreg_flag_merge #(.DATA_W(DATA_W)) u_merge (
    .cur      (sr[5:0]),
    .alu_we   (alu_we),
    .alu_mask (alu_mask),
    .op_a     (op_a),
    .op_b     (op_b),
    .res      (alu_res),
    .cout     (alu_cout),
    .merged   (merged),
    .alu_evt  (alu_evt)
  );

  sreg_tbit #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_tbit (
    .cur_t    (sr[FB_T]),
    .bst_en   (bst_en),
    .bst_src  (bst_src),
    .bit_sel  (bit_sel),
    .bld_dst  (bld_dst),
    .t_next   (t_next),
    .bld_res  (bld_res)
  );

  sreg_ie_ctrl u_ie (
    .cur_i       (sr[FB_I]),
    .sw_we       (sw_we),
    .sw_i        (sw_data[FB_I]),
    .reti        (reti),
    .irq_take    (irq_take),
    .irq_pending (irq_pending),
    .i_next      (i_next),
    .irq_permit  (irq_permit),
    .ev_take     (ev_take),
    .ev_ret      (ev_ret)
  );

  assign ev_bst = bst_en & ~sw_we;

  always_comb begin
    if (sw_we) body = sw_data;
    else       body = {sr[FB_I], t_next, merged};
    body[FB_I] = i_next;
    sr_nxt     = sign_fix(body);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_nxt;
  end

  assign sreg_q = sr;
  assign t_out  = sr[FB_T];

  // R4: stored sign always consistent
  p_sign_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sr[FB_S] == (sr[FB_N] ^ sr[FB_V]));

  // R6: accepted interrupt leaves I clear
  p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> !sr[FB_I]);

  // R7: return sets I when not overridden
  p_ret_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ret |=> sr[FB_I]);

  // R5: software write lands on all non-derived, non-enable bits
  p_sw_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (sr[6:5] == $past(sw_data[6:5])) && (sr[3:0] == $past(sw_data[3:0])));

  // R3: unmasked carry held through an ALU-only cycle
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !sw_we && !alu_mask[FB_C]) |=> $stable(sr[FB_C]));

  // R8: bit-store reaches T
  p_bst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bst |=> sr[FB_T] == $past(bst_src[bit_sel]));

  // R10: permit never without master enable
  p_permit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_permit |-> sr[FB_I]);

  // R3: an ALU-only cycle never moves I or T
  p_alu_it_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_evt && !sw_we && !bst_en && !reti && !irq_take) |=> $stable(sr[7:6]));
endmodule

// File: tb/sim_cpu_flag_reg.sv
module sim_cpu_flag_reg;
  localparam int CLK_NS = 10;
  localparam int NV = 8;
  // {a, b, mask}
  localparam logic [23:0] VEC [NV] = '{
    {8'h0F, 8'h01, 8'hFF},
    {8'h7F, 8'h01, 8'h2F},
    {8'hFF, 8'h01, 8'h2F},
    {8'h80, 8'h80, 8'h2F},
    {8'h12, 8'h34, 8'h0E},
    {8'hF0, 8'h20, 8'h01},
    {8'h55, 8'hAA, 8'h00},
    {8'h40, 8'h40, 8'h2F}
  };

  logic clk = 0;
  logic rst_n;
  logic alu_we, alu_cout, sw_we, bst_en, irq_take, reti, irq_pending;
  logic [7:0] alu_mask, op_a, op_b, alu_res, sw_data, bst_src, bld_dst;
  logic [2:0] bit_sel;
  logic [7:0] sreg_q, bld_res;
  logic t_out, irq_permit;
  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl;

  always #(CLK_NS/2) clk = ~clk;

  cpu_flag_reg u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    alu_we = 0; sw_we = 0; bst_en = 0; irq_take = 0; reti = 0;
  endtask

  task automatic alu_set(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    alu_we = 1; op_a = a; op_b = b; alu_mask = m;
    alu_res = s[7:0]; alu_cout = s[8];
  endtask

  // own restatement of the flag rules
  function automatic logic [7:0] exp_alu(input logic [7:0] prev, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] m);
    int sum, ssum, nib;
    logic [7:0] r, f;
    sum  = int'(a) + int'(b);
    ssum = int'($signed(a)) + int'($signed(b));
    nib  = int'(a[3:0]) + int'(b[3:0]);
    r    = sum[7:0];
    f    = prev;
    if (m[5]) f[5] = (nib > 15);
    if (m[3]) f[3] = (ssum > 127) || (ssum < -128);
    if (m[2]) f[2] = r[7];
    if (m[1]) f[1] = (r == 8'h00);
    if (m[0]) f[0] = (sum > 255);
    f[4] = f[2] ^ f[3];
    return f;
  endfunction

  initial begin
    #(CLK_NS * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle();
    alu_mask = 0; op_a = 0; op_b = 0; alu_res = 0; alu_cout = 0;
    sw_data = 0; bst_src = 0; bit_sel = 0; bld_dst = 0; irq_pending = 1;
    repeat (3) tick();
    chk("R1 reset value", sreg_q, 8'h00);
    chk("R1 reset T", {7'd0, t_out}, 8'h00);
    chk("R10 permit at reset", {7'd0, irq_permit}, 8'h00);
    rst_n = 1;

    sw_we = 1; sw_data = 8'hC0; tick(); idle(); mdl = 8'hC0;
    chk("R5 write I and T", sreg_q, mdl);

    for (int i = 0; i < NV; i++) begin
      alu_set(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
      tick(); idle();
      mdl = exp_alu(mdl, VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
      chk($sformatf("R2 R3 vector %0d", i), sreg_q, mdl);
    end

    sw_we = 1; sw_data = 8'h30; tick(); idle();
    chk("R4 R5 inconsistent S rewritten", sreg_q, 8'h20);

    sw_we = 1; sw_data = 8'h00; reti = 1; bst_en = 1; bst_src = 8'hFF; bit_sel = 0;
    alu_set(8'hFF, 8'h01, 8'h2F); tick(); idle();
    chk("R5 write wins over reti alu bst", sreg_q, 8'h00);

    sw_we = 1; sw_data = 8'h6B; tick(); idle();
    chk("R4 R5 write 6B", sreg_q, 8'h7B);
    reti = 1; tick(); idle();
    chk("R7 R11 reti alone", sreg_q, 8'hFB);
    irq_take = 1; tick(); idle();
    chk("R6 R11 take alone", sreg_q, 8'h7B);
    irq_take = 1; sw_we = 1; sw_data = 8'h80; tick(); idle();
    chk("R6 take beats write", sreg_q, 8'h00);
    irq_take = 1; reti = 1; tick(); idle();
    chk("R6 take beats reti", sreg_q, 8'h00);
    reti = 1; alu_set(8'h7F, 8'h01, 8'h2F); tick(); idle();
    chk("R7 reti with alu", sreg_q, 8'hAC);

    irq_pending = 1; #1;
    chk("R10 permit on", {7'd0, irq_permit}, 8'h01);
    irq_pending = 0; #1;
    chk("R10 permit off", {7'd0, irq_permit}, 8'h00);

    bst_src = 8'hA5;
    for (int k = 0; k < 8; k++) begin
      bst_en = 1; bit_sel = 3'(k); tick(); idle();
      chk($sformatf("R8 bst bit %0d", k), {7'd0, t_out}, {7'd0, bst_src[k]});
    end

    sw_we = 1; sw_data = 8'h40; tick(); idle();
    bld_dst = 8'h00; bit_sel = 3'd5; #1;
    chk("R9 bld sel5 T1", bld_res, 8'h20);
    bit_sel = 3'd7; #1;
    chk("R9 bld sel7 T1", bld_res, 8'h80);
    sw_we = 1; sw_data = 8'h00; tick(); idle();
    bld_dst = 8'hFF; bit_sel = 3'd2; #1;
    chk("R9 bld sel2 T0", bld_res, 8'hFB);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule